// File: doc/BRIEF.md
# Collision-Free Instruction Planner

The planner sits between several instruction pipelines and a wide data crossbar. In every cycle each input slot may offer one atomic transfer instruction. Such an instruction moves one data block from a row and column of the source buffer to a row and column of the destination buffer, and it carries a 1-bit color tag. The planner picks a subset of the offered instructions that the crossbar can run in parallel. In that subset no two instructions read the same source row and no two write the same destination row. It raises a per-slot accept for each chosen instruction. On the next cycle it presents the chosen instructions on a registered issue port.

The planner serves one color at a time. An instruction whose tag differs from the served color is ignored until the color changes. When no instruction of the served color has been offered for a full timeout window, the phase is closed. The planner then toggles its color and, after a configurable delay, emits a one-cycle confirmation that names the finished color. Upstream logic tags newer work with the other color. Because of this, a confirmation tells the consumer that every block of the finished color has reached the destination buffer. This keeps completion reporting in order and means no instruction waits forever.

Top module: `instr_planner`

## Requirements
- R1: In any cycle, no two accepted instructions have the same source row.
- R2: In any cycle, no two accepted instructions have the same destination row.
- R3: An accept is raised only for a slot whose valid is high and whose color bit equals `cur_color`. Instructions of the other color are never accepted while that color is not being served.
- R4: Selection scans slots from index 0 upward. An eligible instruction is accepted exactly when neither its source row nor its destination row is already used by a lower-index instruction accepted in the same cycle.
- R5: One cycle after a cycle with accepts, `iss_vld` equals that cycle's accept vector. Each slot with `iss_vld` high carries the source row, source column, destination row and destination column that its instruction had when it was accepted.
- R6: `cur_color` toggles only after 2**TMO_W consecutive cycles in which no valid instruction of the served color is offered. Any cycle with such an instruction restarts the count.
- R7: A toggle of `cur_color` is followed by exactly one cycle of `conf_vld`, CONF_DLY cycles after the edge that toggled it (counting that edge's register as the first). `conf_color` then carries the color that was just closed.
- R8: After reset, `cur_color` is 0 and `iss_vld` and `conf_vld` are low.
- R9: An instruction that is not chosen stays eligible in later cycles. If the offering slot withdraws each instruction once it is accepted, every offered instruction is accepted exactly once and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | N_IN | Instruction present, one bit per slot |
| in_color | input | N_IN | Color tag, one bit per slot |
| in_src_row | input | N_IN*SRW | Source row, SRW bits per slot, slot 0 in the low bits |
| in_src_col | input | N_IN*SCW | Source column per slot |
| in_dst_row | input | N_IN*DRW | Destination row per slot |
| in_dst_col | input | N_IN*DCW | Destination column per slot |
| in_acc | output | N_IN | Combinational accept per slot |
| iss_vld | output | N_IN | Registered issue valid per slot |
| iss_src_row | output | N_IN*SRW | Issued source row per slot |
| iss_src_col | output | N_IN*SCW | Issued source column per slot |
| iss_dst_row | output | N_IN*DRW | Issued destination row per slot |
| iss_dst_col | output | N_IN*DCW | Issued destination column per slot |
| cur_color | output | 1 | Color currently served |
| conf_vld | output | 1 | One-cycle confirmation of a closed color |
| conf_color | output | 1 | Color being confirmed |

## Verification
The assertions assume that each row index on the input is below the row count of its buffer, and that an offered instruction is held steady on its slot until it is accepted. The bench keeps every slot's head instruction on the pins until the accept is seen and then pops it from that slot's queue. All row values come from a bounded generator. Stimulus covers random row clashes, a stream in which every instruction uses the same source row, slots blocked by work of the other color, and arrivals spaced just inside the timeout window, so both color phases are exercised in turn.

// File: rtl/plan_pkg.sv
package plan_pkg;
  // Index width for a count of entries; never below one bit.
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // An instruction counts for the current phase only with a matching tag.
  function automatic logic color_ok(logic v, logic c, logic cur);
    return v && (c == cur);
  endfunction

  // Last count value of a timeout window that lasts 2**w cycles.
  function automatic int unsigned window_last(int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/plan_select.sv
module plan_select #(
  parameter int N_IN     = 4,
  parameter int SRC_ROWS = 4,
  parameter int DST_ROWS = 4,
  parameter int SRW      = 2,
  parameter int DRW      = 2
) (
  input  logic [N_IN-1:0]     vld,
  input  logic [N_IN-1:0]     color,
  input  logic                cur,
  input  logic [N_IN*SRW-1:0] src_row,
  input  logic [N_IN*DRW-1:0] dst_row,
  output logic [N_IN-1:0]     acc,
  output logic                any_match
);
  import plan_pkg::*;

  logic [SRC_ROWS-1:0] src_busy;
  logic [DST_ROWS-1:0] dst_busy;

  // Greedy scan from slot 0: take an eligible slot if both rows are free.
  always_comb begin
    src_busy  = '0;
    dst_busy  = '0;
    acc       = '0;
    any_match = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (color_ok(vld[i], color[i], cur)) begin
        any_match = 1'b1;
        if (!src_busy[src_row[i*SRW +: SRW]] && !dst_busy[dst_row[i*DRW +: DRW]]) begin
          acc[i]                        = 1'b1;
          src_busy[src_row[i*SRW +: SRW]] = 1'b1;
          dst_busy[dst_row[i*DRW +: DRW]] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/plan_color_ctl.sv
module plan_color_ctl #(
  parameter int TMO_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic any_match,
  output logic cur,
  output logic flip,
  output logic flip_color
);
  import plan_pkg::*;

  localparam logic [TMO_W-1:0] LAST = TMO_W'(window_last(TMO_W));

  logic [TMO_W-1:0] idle_cnt;

  assign flip       = !any_match && (idle_cnt == LAST);
  assign flip_color = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= 1'b0;
      idle_cnt <= '0;
    end else if (any_match) begin
      idle_cnt <= '0;
    end else if (flip) begin
      idle_cnt <= '0;
      cur      <= ~cur;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/plan_conf_delay.sv
module plan_conf_delay #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_pulse,
  input  logic in_color,
  output logic out_pulse,
  output logic out_color
);
  logic [DLY-1:0] pv;
  logic [DLY-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      pc <= '0;
    end else begin
      pv[0] <= in_pulse;
      pc[0] <= in_color;
      for (int k = 1; k < DLY; k++) begin
        pv[k] <= pv[k-1];
        pc[k] <= pc[k-1];
      end
    end
  end

  assign out_pulse = pv[DLY-1];
  assign out_color = pc[DLY-1];
endmodule

// File: rtl/plan_issue_reg.sv
module plan_issue_reg #(
  parameter int N_IN = 4,
  parameter int SRW  = 2,
  parameter int SCW  = 3,
  parameter int DRW  = 2,
  parameter int DCW  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_IN-1:0]     acc,
  input  logic [N_IN*SRW-1:0] src_row,
  input  logic [N_IN*SCW-1:0] src_col,
  input  logic [N_IN*DRW-1:0] dst_row,
  input  logic [N_IN*DCW-1:0] dst_col,
  output logic [N_IN-1:0]     o_vld,
  output logic [N_IN*SRW-1:0] o_src_row,
  output logic [N_IN*SCW-1:0] o_src_col,
  output logic [N_IN*DRW-1:0] o_dst_row,
  output logic [N_IN*DCW-1:0] o_dst_col
);
  always_ff @(posedge clk) begin
    if (rst) o_vld <= '0;
    else     o_vld <= acc;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (acc[g]) begin
        o_src_row[g*SRW +: SRW] <= src_row[g*SRW +: SRW];
        o_src_col[g*SCW +: SCW] <= src_col[g*SCW +: SCW];
        o_dst_row[g*DRW +: DRW] <= dst_row[g*DRW +: DRW];
        o_dst_col[g*DCW +: DCW] <= dst_col[g*DCW +: DCW];
      end
    end
  end
endmodule

// File: rtl/instr_planner.sv
module instr_planner #(
  parameter int N_IN     = 4,
  parameter int SRC_ROWS = 4,
  parameter int DST_ROWS = 4,
  parameter int SRC_COLS = 8,
  parameter int DST_COLS = 8,
  parameter int TMO_W    = 3,
  parameter int CONF_DLY = 2,
  localparam int SRW = plan_pkg::idx_w(SRC_ROWS),
  localparam int SCW = plan_pkg::idx_w(SRC_COLS),
  localparam int DRW = plan_pkg::idx_w(DST_ROWS),
  localparam int DCW = plan_pkg::idx_w(DST_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_IN-1:0]     in_vld,
  input  logic [N_IN-1:0]     in_color,
  input  logic [N_IN*SRW-1:0] in_src_row,
  input  logic [N_IN*SCW-1:0] in_src_col,
  input  logic [N_IN*DRW-1:0] in_dst_row,
  input  logic [N_IN*DCW-1:0] in_dst_col,
  output logic [N_IN-1:0]     in_acc,
  output logic [N_IN-1:0]     iss_vld,
  output logic [N_IN*SRW-1:0] iss_src_row,
  output logic [N_IN*SCW-1:0] iss_src_col,
  output logic [N_IN*DRW-1:0] iss_dst_row,
  output logic [N_IN*DCW-1:0] iss_dst_col,
  output logic                cur_color,
  output logic                conf_vld,
  output logic                conf_color
);
  // Named internal events, visible to the bound checker.
  logic [N_IN-1:0] sel_acc;
  logic            cur_match;
  logic            flip_ev;
  logic            flip_col;

  plan_select #(
    .N_IN(N_IN), .SRC_ROWS(SRC_ROWS), .DST_ROWS(DST_ROWS), .SRW(SRW), .DRW(DRW)
  ) u_select (
    .vld(in_vld), .color(in_color), .cur(cur_color),
    .src_row(in_src_row), .dst_row(in_dst_row),
    .acc(sel_acc), .any_match(cur_match)
  );

  plan_color_ctl #(.TMO_W(TMO_W)) u_color (
    .clk(clk), .rst(rst), .any_match(cur_match),
    .cur(cur_color), .flip(flip_ev), .flip_color(flip_col)
  );

  plan_conf_delay #(.DLY(CONF_DLY)) u_conf (
    .clk(clk), .rst(rst), .in_pulse(flip_ev), .in_color(flip_col),
    .out_pulse(conf_vld), .out_color(conf_color)
  );

  plan_issue_reg #(
    .N_IN(N_IN), .SRW(SRW), .SCW(SCW), .DRW(DRW), .DCW(DCW)
  ) u_issue (
    .clk(clk), .rst(rst), .acc(sel_acc),
    .src_row(in_src_row), .src_col(in_src_col),
    .dst_row(in_dst_row), .dst_col(in_dst_col),
    .o_vld(iss_vld), .o_src_row(iss_src_row), .o_src_col(iss_src_col),
    .o_dst_row(iss_dst_row), .o_dst_col(iss_dst_col)
  );

  assign in_acc = sel_acc;
endmodule

// File: rtl/instr_planner_chk.sv
module instr_planner_chk #(
  parameter int N_IN  = 4,
  parameter int SRW   = 2,
  parameter int DRW   = 2,
  parameter int TMO_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [N_IN-1:0]     in_vld,
  input logic [N_IN-1:0]     in_color,
  input logic [N_IN*SRW-1:0] in_src_row,
  input logic [N_IN*DRW-1:0] in_dst_row,
  input logic [N_IN-1:0]     in_acc,
  input logic [N_IN-1:0]     iss_vld,
  input logic                cur_color,
  input logic                conf_vld,
  input logic                cur_match,
  input logic                flip_ev
);
  logic        past_ok;
  int unsigned idle_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok  <= 1'b0;
      idle_run <= 0;
    end else begin
      past_ok <= 1'b1;
      if (cur_match || flip_ev) idle_run <= 0;
      else                      idle_run <= idle_run + 1;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_i
    // R3: accepted slot is valid and tagged with the served color
    a_r3_color_match: assert property (@(posedge clk) disable iff (rst)
      in_acc[i] |-> (in_vld[i] && (in_color[i] == cur_color)));
    for (genvar j = i + 1; j < N_IN; j++) begin : g_j
      // R1: no shared source row among same-cycle accepts
      a_r1_src_distinct: assert property (@(posedge clk) disable iff (rst)
        !(in_acc[i] && in_acc[j] && (in_src_row[i*SRW +: SRW] == in_src_row[j*SRW +: SRW])));
      // R2: no shared destination row among same-cycle accepts
      a_r2_dst_distinct: assert property (@(posedge clk) disable iff (rst)
        !(in_acc[i] && in_acc[j] && (in_dst_row[i*DRW +: DRW] == in_dst_row[j*DRW +: DRW])));
    end
  end

  // R5: issue valid mirrors the previous cycle's accepts
  a_r5_issue_follows: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (iss_vld == $past(in_acc)));

  // R6: a served-color offer keeps the color for the next cycle
  a_r6_match_holds: assert property (@(posedge clk) disable iff (rst)
    cur_match |=> $stable(cur_color));

  // R6: a toggle only after a full idle window, checked by counter
  a_r6_full_window: assert property (@(posedge clk) disable iff (rst)
    flip_ev |-> (idle_run == (32'd1 << TMO_W) - 32'd1));

  // R7: confirmation lasts a single cycle
  a_r7_conf_single: assert property (@(posedge clk) disable iff (rst)
    conf_vld |=> !conf_vld);
endmodule

bind instr_planner instr_planner_chk #(
  .N_IN(N_IN), .SRW(SRW), .DRW(DRW), .TMO_W(TMO_W)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_color(in_color),
  .in_src_row(in_src_row), .in_dst_row(in_dst_row), .in_acc(in_acc),
  .iss_vld(iss_vld), .cur_color(cur_color), .conf_vld(conf_vld),
  .cur_match(cur_match), .flip_ev(flip_ev)
);

// File: tb/instr_planner_bench.sv
`timescale 1ns/1ps
module instr_planner_bench;
  localparam int N = 4;
  localparam int W = 3;
  localparam int D = 2;
  localparam int WINDOW = 8;          // 2**W idle cycles
  localparam int CYCLE_CAP = 20000;

  typedef struct packed {
    logic        color;
    logic [1:0]  sr;
    logic [2:0]  sc;
    logic [1:0]  dr;
    logic [2:0]  dc;
    logic [15:0] id;
  } ins_t;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   in_vld, in_color;
  logic [N*2-1:0] in_src_row, in_dst_row;
  logic [N*3-1:0] in_src_col, in_dst_col;
  logic [N-1:0]   in_acc, iss_vld;
  logic [N*2-1:0] iss_src_row, iss_dst_row;
  logic [N*3-1:0] iss_src_col, iss_dst_col;
  logic           cur_color, conf_vld, conf_color;

  always #2.5 clk = ~clk;

  instr_planner #(
    .N_IN(N), .SRC_ROWS(4), .DST_ROWS(4), .SRC_COLS(8), .DST_COLS(8),
    .TMO_W(W), .CONF_DLY(D)
  ) u_instr_planner (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_color(in_color),
    .in_src_row(in_src_row), .in_src_col(in_src_col),
    .in_dst_row(in_dst_row), .in_dst_col(in_dst_col),
    .in_acc(in_acc), .iss_vld(iss_vld),
    .iss_src_row(iss_src_row), .iss_src_col(iss_src_col),
    .iss_dst_row(iss_dst_row), .iss_dst_col(iss_dst_col),
    .cur_color(cur_color), .conf_vld(conf_vld), .conf_color(conf_color)
  );

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  int   cycles = 0;
  ins_t q [N][$];
  int   seen [0:1023];
  int   next_id = 0;
  int   injected = 0;
  int   accepted = 0;
  int   rng = 32'h1ace;

  // reference model state
  bit   m_color = 0;
  int   m_idle = 0;
  int   edge_no = 0;
  bit   flip_at [int];
  bit   x_iss_vld [N];
  ins_t x_iss [N];

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(int m);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return (rng & 32'h7fffffff) % m;
  endfunction

  task automatic push(int s, bit c, int sr, int dr);
    ins_t x;
    x.color = c; x.sr = 2'(sr); x.dr = 2'(dr);
    x.sc = 3'(rnd(8)); x.dc = 3'(rnd(8)); x.id = 16'(next_id);
    next_id++; injected++;
    q[s].push_back(x);
  endtask

  function automatic bit queues_busy();
    for (int s = 0; s < N; s++) if (q[s].size() != 0) return 1;
    return 0;
  endfunction

  task automatic step();
    bit   e_acc [N];
    bit   used_s [4];
    bit   used_d [4];
    bit   match;
    ins_t h [N];
    bit   hv [N];
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      hv[s] = (q[s].size() != 0);
      h[s]  = hv[s] ? q[s][0] : '0;
      in_vld[s]          = hv[s];
      in_color[s]        = h[s].color;
      in_src_row[s*2 +: 2] = h[s].sr;
      in_dst_row[s*2 +: 2] = h[s].dr;
      in_src_col[s*3 +: 3] = h[s].sc;
      in_dst_col[s*3 +: 3] = h[s].dc;
    end
    #1;
    // expected selection: walk slots in order, remember claimed rows
    match = 0;
    for (int r = 0; r < 4; r++) begin used_s[r] = 0; used_d[r] = 0; end
    for (int s = 0; s < N; s++) begin
      e_acc[s] = 0;
      if (hv[s] && h[s].color == m_color) begin
        match = 1;
        if (!used_s[h[s].sr] && !used_d[h[s].dr]) begin
          e_acc[s] = 1; used_s[h[s].sr] = 1; used_d[h[s].dr] = 1;
        end
      end
    end
    for (int s = 0; s < N; s++) begin
      chk("R4", $sformatf("accept slot %0d", s), int'(in_acc[s]), int'(e_acc[s]));
      if (in_acc[s] && (!hv[s] || h[s].color != m_color))
        chk("R3", "accept of ineligible slot", 1, 0);
      for (int t = s + 1; t < N; t++) if (in_acc[s] && in_acc[t]) begin
        chk("R1", "source rows differ", int'(in_src_row[s*2 +: 2] == in_src_row[t*2 +: 2]), 0);
        chk("R2", "destination rows differ", int'(in_dst_row[s*2 +: 2] == in_dst_row[t*2 +: 2]), 0);
      end
      chk("R5", $sformatf("issue valid slot %0d", s), int'(iss_vld[s]), int'(x_iss_vld[s]));
      if (x_iss_vld[s]) begin
        chk("R5", "issue source row", int'(iss_src_row[s*2 +: 2]), int'(x_iss[s].sr));
        chk("R5", "issue source col", int'(iss_src_col[s*3 +: 3]), int'(x_iss[s].sc));
        chk("R5", "issue dest row", int'(iss_dst_row[s*2 +: 2]), int'(x_iss[s].dr));
        chk("R5", "issue dest col", int'(iss_dst_col[s*3 +: 3]), int'(x_iss[s].dc));
      end
    end
    chk("R6", "served color", int'(cur_color), int'(m_color));
    chk("R7", "confirmation pulse", int'(conf_vld), int'(flip_at.exists(edge_no - (D - 1))));
    if (flip_at.exists(edge_no - (D - 1)))
      chk("R7", "confirmed color", int'(conf_color), int'(flip_at[edge_no - (D - 1)]));
    // advance model for the coming edge
    for (int s = 0; s < N; s++) begin
      x_iss_vld[s] = e_acc[s];
      if (e_acc[s]) begin
        x_iss[s] = h[s];
        seen[h[s].id]++;
        accepted++;
        void'(q[s].pop_front());
      end
    end
    if (match) m_idle = 0;
    else if (m_idle == WINDOW - 1) begin
      flip_at[edge_no + 1] = m_color;
      m_color = ~m_color;
      m_idle = 0;
    end else m_idle++;
    @(posedge clk);
    edge_no++;
    cycles++;
  endtask

  task automatic drain();
    while (queues_busy() && cycles < CYCLE_CAP) step();
    if (queues_busy()) chk("R9", "queues drained before cap", 0, 1);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 1024; k++) seen[k] = 0;
    for (int s = 0; s < N; s++) begin x_iss_vld[s] = 0; x_iss[s] = '0; end
    rst = 1; in_vld = '0; in_color = '0;
    in_src_row = '0; in_dst_row = '0; in_src_col = '0; in_dst_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R8", "color after reset", int'(cur_color), 0);
    chk("R8", "issue after reset", int'(iss_vld), 0);
    chk("R8", "confirm after reset", int'(conf_vld), 0);
    @(posedge clk);
    edge_no = 1;

    // random clashes, served color 0 (R1, R2, R4)
    for (int k = 0; k < 40; k++) push(rnd(N), 0, rnd(4), rnd(4));
    drain();
    idle(WINDOW + 4);                    // closes color 0 (R6, R7)
    chk("R6", "toggle after idle window", int'(cur_color), 1);

    // one shared source row: at most one accept per cycle
    for (int k = 0; k < 12; k++) push(k % N, 1, 2, k % 4);
    drain();

    // other color parked on slots 0 and 1 while color 1 runs (R3)
    for (int k = 0; k < 6; k++) begin
      push(0, 0, rnd(4), rnd(4));
      push(1, 0, rnd(4), rnd(4));
      push(2, 1, rnd(4), rnd(4));
      push(3, 1, rnd(4), rnd(4));
    end
    drain();

    // arrivals inside the window keep the color (R6)
    for (int k = 0; k < 4; k++) begin
      idle(WINDOW - 2);
      push(rnd(N), m_color, rnd(4), rnd(4));
      drain();
    end
    idle(WINDOW + 4);

    for (int k = 0; k < next_id; k++)
      chk("R9", $sformatf("instruction %0d accepted once", k), seen[k], 1);
    chk("R9", "accepted total", accepted, injected);
    finish_run();
  end
endmodule